// File: doc/BRIEF.md
# Stream-Triggered Configuration Write Sequencer

This block sits in the middle of a packetised video stream that uses valid/ready handshaking. While idle, it forwards every beat unchanged. It also parses packet headers, looking for two kinds of event: the first beat of a video data packet, and a change in the width or height carried by a control packet.

When an event is seen and triggering is armed, the block does not accept the beat that caused it. Instead it replays a list of address/data register writes, programmed in advance by software, through a single-beat memory-mapped master. Only after the last of those writes has been accepted does it let the held beat go. Downstream blocks with no buffering in between are stalled by the same back-pressure, so they pick up their new settings exactly at the packet boundary. A sticky completion flag, gated by an interrupt enable, tells software that the sequence has finished.

Software uses two register ports. The configuration port holds the write count and eight address/data pairs. The control port holds the trigger enable, the interrupt enable and the completion flag.

Top module: `frame_cfg_sequencer`

## Requirements
- R1: Whenever no write sequence is active and no trigger is being taken, m_valid_o follows s_valid_i, s_ready_o follows m_ready_i, and data, start and end flags pass from input to output without change.
- R2: A beat with s_sop_i high whose low nibble is 0x0 (video data) is a trigger event. A first beat with any other type nibble (other than the control case of R3) is not.
- R3: In a control packet (type nibble 0xF on the first beat), the low 16 bits of beat 1 are the width and the low 16 bits of beat 2 are the height. A field that differs from its stored copy is a trigger event, firing on the beat that carries it. A control packet fires at most once. The stored copies reset to zero and are updated whenever those beats pass, whether or not triggering is enabled.
- R4: On a trigger, pair k is written for k = 0 up to count-1 in ascending order, one write at a time. The address comes from configuration offset 2k+1 and the data from offset 2k+2. Address and data are held stable while mst_waitreq_i is high.
- R5: From the cycle the trigger is taken until the last write is accepted, m_valid_o and s_ready_o are low. The triggering beat is then forwarded unchanged and does not fire a second time.
- R6: The write count lives at configuration offset 0. A value above 8 is stored as 8. With a count of 0, an event causes no stall, no writes and no completion flag.
- R7: Control offset 0 bit 0 enables triggering. While it is clear, events cause no stall and no writes.
- R8: When the ONE_SHOT parameter is 1, taking a trigger clears the trigger enable bit.
- R9: The acceptance of the last write sets the completion flag (control offset 1, bit 0). Writing 1 to that bit clears it; writing 0 leaves it set. irq_o is the flag ANDed with control offset 0 bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_valid_i | input | 1 | Upstream beat valid |
| s_ready_o | output | 1 | Upstream beat accepted |
| s_data_i | input | SDW | Upstream beat data |
| s_sop_i | input | 1 | Upstream first beat of packet |
| s_eop_i | input | 1 | Upstream last beat of packet |
| m_valid_o | output | 1 | Downstream beat valid |
| m_ready_i | input | 1 | Downstream ready |
| m_data_o | output | SDW | Downstream beat data |
| m_sop_o | output | 1 | Downstream first beat of packet |
| m_eop_o | output | 1 | Downstream last beat of packet |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_addr_i | input | CAW | Configuration register offset |
| cfg_wdata_i | input | DW | Configuration register write data |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_addr_i | input | 1 | Control register offset |
| ctl_wdata_i | input | DW | Control register write data |
| ctl_rdata_o | output | DW | Control register read data |
| mst_write_o | output | 1 | Master write request |
| mst_addr_o | output | AW | Master write address |
| mst_wdata_o | output | DW | Master write data |
| mst_waitreq_i | input | 1 | Master wait request, holds the current write |
| irq_o | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is a control packet in which both width and height change. The second field must be suppressed even though the block has just left a write sequence, so that the packet fires exactly once. The bench first lets dimensions be learned while triggering is disabled. It then sends a packet that changes both fields and counts the master writes, then sends a packet that changes only the height. Every master write is logged with its cycle, alongside every forwarded beat. This shows the held beat leaving only after the last write, including when the bench stretches each write with wait requests.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_WRITE  = 2'd1,
    ENG_RESUME = 2'd2
  } eng_state_e;

  localparam logic [3:0] PKT_VIDEO = 4'h0;
  localparam logic [3:0] PKT_CTRL  = 4'hF;

  localparam int CTL_BIT_TRIG = 0;
  localparam int CTL_BIT_IRQ  = 1;
  localparam int CTL_BIT_PEND = 0;
endpackage

// File: rtl/fcs_regfile.sv
module fcs_regfile
  import fcs_pkg::*;
#(
  parameter int NPAIR = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CAW   = 5,
  parameter int CW    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [CAW-1:0]            cfg_addr_i,
  input  logic [DW-1:0]             cfg_wdata_i,
  input  logic                      ctl_we_i,
  input  logic                      ctl_addr_i,
  input  logic [DW-1:0]             ctl_wdata_i,
  output logic [DW-1:0]             ctl_rdata_o,
  input  logic                      oneshot_clr_i,
  input  logic                      done_i,
  output logic [CW-1:0]             count_o,
  output logic [NPAIR-1:0][AW-1:0]  pair_addr_o,
  output logic [NPAIR-1:0][DW-1:0]  pair_data_o,
  output logic                      trig_en_o,
  output logic                      irq_pend_o,
  output logic                      irq_o
);
  logic trig_en_q, irq_en_q, pend_q;
  logic [CW-1:0] count_q;
  logic unused_ctl;

  assign unused_ctl = ^ctl_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (cfg_we_i && cfg_addr_i == '0) begin
      if (cfg_wdata_i > DW'(NPAIR)) count_q <= CW'(NPAIR);
      else                          count_q <= cfg_wdata_i[CW-1:0];
    end
  end

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= '0;
        d_q <= '0;
      end else if (cfg_we_i) begin
        if (cfg_addr_i == CAW'(2*k+1)) a_q <= cfg_wdata_i[AW-1:0];
        if (cfg_addr_i == CAW'(2*k+2)) d_q <= cfg_wdata_i;
      end
    end
    assign pair_addr_o[k] = a_q;
    assign pair_data_o[k] = d_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_en_q <= 1'b0;
      irq_en_q  <= 1'b0;
    end else begin
      if (ctl_we_i && !ctl_addr_i) begin
        trig_en_q <= ctl_wdata_i[CTL_BIT_TRIG];
        irq_en_q  <= ctl_wdata_i[CTL_BIT_IRQ];
      end
      if (oneshot_clr_i) trig_en_q <= 1'b0;
    end
  end

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                            pend_q <= 1'b0;
    else if (done_i)                                        pend_q <= 1'b1;
    else if (ctl_we_i && ctl_addr_i && ctl_wdata_i[CTL_BIT_PEND]) pend_q <= 1'b0;
  end

  always_comb begin
    ctl_rdata_o = '0;
    if (ctl_addr_i) begin
      ctl_rdata_o[CTL_BIT_PEND] = pend_q;
    end else begin
      ctl_rdata_o[CTL_BIT_TRIG] = trig_en_q;
      ctl_rdata_o[CTL_BIT_IRQ]  = irq_en_q;
    end
  end

  assign count_o    = count_q;
  assign trig_en_o  = trig_en_q;
  assign irq_pend_o = pend_q;
  assign irq_o      = pend_q & irq_en_q;
endmodule

// File: rtl/fcs_trigger_detect.sv
module fcs_trigger_detect
  import fcs_pkg::*;
#(
  parameter int SDW  = 24,
  parameter int DIMW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [SDW-1:0] data_i,
  input  logic           sop_i,
  input  logic           acc_i,
  input  logic           arm_i,
  output logic           trig_o
);
  logic [1:0]      idx_q;
  logic [3:0]      type_q;
  logic [DIMW-1:0] wid_q, hgt_q;
  logic            fired_q;
  logic [DIMW-1:0] field;
  logic            ctrl_body, vid_ev, wid_ev, hgt_ev;
  logic            unused_data;

  assign unused_data = ^data_i;
  assign field     = data_i[DIMW-1:0];
  assign ctrl_body = !sop_i && type_q == PKT_CTRL;
  assign vid_ev    = sop_i && data_i[3:0] == PKT_VIDEO;
  assign wid_ev    = ctrl_body && idx_q == 2'd1 && field != wid_q;
  assign hgt_ev    = ctrl_body && idx_q == 2'd2 && field != hgt_q && !fired_q;
  assign trig_o    = arm_i && valid_i && (vid_ev || wid_ev || hgt_ev);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      type_q  <= '0;
      wid_q   <= '0;
      hgt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (acc_i) begin
        if (sop_i) begin
          idx_q   <= 2'd1;
          type_q  <= data_i[3:0];
          fired_q <= 1'b0;
        end else begin
          if (idx_q != 2'd3) idx_q <= idx_q + 2'd1;
          if (ctrl_body && idx_q == 2'd1) wid_q <= field;
          if (ctrl_body && idx_q == 2'd2) hgt_q <= field;
        end
      end
      if (trig_o && !sop_i) fired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fcs_write_engine.sv
module fcs_write_engine
  import fcs_pkg::*;
#(
  parameter int NPAIR = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [CW-1:0]            cnt_i,
  input  logic [NPAIR-1:0][AW-1:0] pair_addr_i,
  input  logic [NPAIR-1:0][DW-1:0] pair_data_i,
  input  logic                     waitreq_i,
  input  logic                     acc_i,
  output logic [AW-1:0]            mst_addr_o,
  output logic [DW-1:0]            mst_wdata_o,
  output logic                     mst_write_o,
  output logic                     busy_o,
  output logic                     idle_o,
  output logic                     done_o
);
  localparam int PW = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  eng_state_e      state_q;
  logic [PW-1:0]   ptr_q, nxt;
  logic [CW-1:0]   cnt_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;
  logic            last;

  assign nxt  = ptr_q + PW'(1);
  assign last = CW'(ptr_q) == cnt_q - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: if (start_i) begin
          state_q <= ENG_WRITE;
          ptr_q   <= '0;
          cnt_q   <= cnt_i;
          addr_q  <= pair_addr_i[0];
          data_q  <= pair_data_i[0];
        end
        ENG_WRITE: if (!waitreq_i) begin
          if (last) begin
            state_q <= ENG_RESUME;
          end else begin
            ptr_q  <= nxt;
            addr_q <= pair_addr_i[nxt];
            data_q <= pair_data_i[nxt];
          end
        end
        ENG_RESUME: if (acc_i) state_q <= ENG_IDLE;
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign mst_write_o = state_q == ENG_WRITE;
  assign mst_addr_o  = addr_q;
  assign mst_wdata_o = data_q;
  assign busy_o      = state_q == ENG_WRITE;
  assign idle_o      = state_q == ENG_IDLE;
  assign done_o      = state_q == ENG_WRITE && !waitreq_i && last;
endmodule

// File: rtl/frame_cfg_sequencer.sv
module frame_cfg_sequencer
  import fcs_pkg::*;
#(
  parameter int NPAIR    = 8,
  parameter int SDW      = 24,
  parameter int DIMW     = 16,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter bit ONE_SHOT = 1'b0,
  localparam int CAW     = $clog2(2*NPAIR+1),
  localparam int CW      = $clog2(NPAIR+1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           s_valid_i,
  output logic           s_ready_o,
  input  logic [SDW-1:0] s_data_i,
  input  logic           s_sop_i,
  input  logic           s_eop_i,
  output logic           m_valid_o,
  input  logic           m_ready_i,
  output logic [SDW-1:0] m_data_o,
  output logic           m_sop_o,
  output logic           m_eop_o,
  input  logic           cfg_we_i,
  input  logic [CAW-1:0] cfg_addr_i,
  input  logic [DW-1:0]  cfg_wdata_i,
  input  logic           ctl_we_i,
  input  logic           ctl_addr_i,
  input  logic [DW-1:0]  ctl_wdata_i,
  output logic [DW-1:0]  ctl_rdata_o,
  output logic           mst_write_o,
  output logic [AW-1:0]  mst_addr_o,
  output logic [DW-1:0]  mst_wdata_o,
  input  logic           mst_waitreq_i,
  output logic           irq_o
);
  logic [CW-1:0]            count;
  logic [NPAIR-1:0][AW-1:0] pair_addr;
  logic [NPAIR-1:0][DW-1:0] pair_data;
  logic trig_en, irq_pend, trig, arm, busy, idle, done, hold, acc;

  assign arm  = idle && trig_en && count != '0;
  assign hold = busy || trig;
  assign s_ready_o = m_ready_i && !hold;
  assign m_valid_o = s_valid_i && !hold;
  assign acc       = s_valid_i && s_ready_o;
  assign m_data_o  = s_data_i;
  assign m_sop_o   = s_sop_i;
  assign m_eop_o   = s_eop_i;

  fcs_regfile #(.NPAIR(NPAIR), .AW(AW), .DW(DW), .CAW(CAW), .CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .ctl_we_i, .ctl_addr_i, .ctl_wdata_i, .ctl_rdata_o,
    .oneshot_clr_i (ONE_SHOT && trig),
    .done_i        (done),
    .count_o       (count),
    .pair_addr_o   (pair_addr),
    .pair_data_o   (pair_data),
    .trig_en_o     (trig_en),
    .irq_pend_o    (irq_pend),
    .irq_o
  );

  fcs_trigger_detect #(.SDW(SDW), .DIMW(DIMW)) u_detect (
    .clk_i, .rst_ni,
    .valid_i (s_valid_i),
    .data_i  (s_data_i),
    .sop_i   (s_sop_i),
    .acc_i   (acc),
    .arm_i   (arm),
    .trig_o  (trig)
  );

  fcs_write_engine #(.NPAIR(NPAIR), .AW(AW), .DW(DW), .CW(CW)) u_eng (
    .clk_i, .rst_ni,
    .start_i     (trig),
    .cnt_i       (count),
    .pair_addr_i (pair_addr),
    .pair_data_i (pair_data),
    .waitreq_i   (mst_waitreq_i),
    .acc_i       (acc),
    .mst_addr_o, .mst_wdata_o, .mst_write_o,
    .busy_o      (busy),
    .idle_o      (idle),
    .done_o      (done)
  );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          s_valid_i,
  input logic          s_ready_o,
  input logic          m_valid_o,
  input logic          m_ready_i,
  input logic          mst_write_o,
  input logic          mst_waitreq_i,
  input logic [AW-1:0] mst_addr_o,
  input logic [DW-1:0] mst_wdata_o,
  input logic          ctl_we_i,
  input logic          ctl_addr_i,
  input logic          ctl_wdata_bit0,
  input logic          irq_pend,
  input logic          irq_o
);
  AST_LOSSLESS_HANDSHAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_valid_i && s_ready_o |-> m_valid_o && m_ready_i); // R1

  AST_STALL_DURING_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_write_o |-> !m_valid_o && !s_ready_o); // R5

  AST_MST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_write_o && mst_waitreq_i |=> mst_write_o && $stable(mst_addr_o) && $stable(mst_wdata_o)); // R4

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_pend); // R9

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pend && !(ctl_we_i && ctl_addr_i && ctl_wdata_bit0) |=> irq_pend); // R9

  AST_DONE_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mst_write_o) |-> irq_pend); // R9
endmodule

bind frame_cfg_sequencer fcs_checker #(.AW(AW), .DW(DW)) u_fcs_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .s_valid_i      (s_valid_i),
  .s_ready_o      (s_ready_o),
  .m_valid_o      (m_valid_o),
  .m_ready_i      (m_ready_i),
  .mst_write_o    (mst_write_o),
  .mst_waitreq_i  (mst_waitreq_i),
  .mst_addr_o     (mst_addr_o),
  .mst_wdata_o    (mst_wdata_o),
  .ctl_we_i       (ctl_we_i),
  .ctl_addr_i     (ctl_addr_i),
  .ctl_wdata_bit0 (ctl_wdata_i[0]),
  .irq_pend       (irq_pend),
  .irq_o          (irq_o)
);

// File: tb/sim_frame_cfg_sequencer.sv
`timescale 1ns/1ps
module sim_frame_cfg_sequencer;
  localparam int SDW = 24;
  localparam int DW  = 32;
  localparam int AW  = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           s_valid = 0, s_sop = 0, s_eop = 0, m_ready = 1;
  logic [SDW-1:0] s_data = '0;
  logic           cfg_we = 0, ctl_we = 0, ctl_addr = 0, waitreq = 0;
  logic [4:0]     cfg_addr = '0;
  logic [DW-1:0]  cfg_wdata = '0, ctl_wdata = '0;

  logic           s_ready, m_valid, m_sop, m_eop, mst_write, irq;
  logic [SDW-1:0] m_data;
  logic [DW-1:0]  ctl_rdata, mst_wdata;
  logic [AW-1:0]  mst_addr;

  logic           s_ready1, m_valid1, m_sop1, m_eop1, mst_write1, irq1;
  logic [SDW-1:0] m_data1;
  logic [DW-1:0]  ctl_rdata1, mst_wdata1;
  logic [AW-1:0]  mst_addr1;

  frame_cfg_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data), .s_sop_i(s_sop), .s_eop_i(s_eop),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data), .m_sop_o(m_sop), .m_eop_o(m_eop),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .ctl_we_i(ctl_we), .ctl_addr_i(ctl_addr), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
    .mst_write_o(mst_write), .mst_addr_o(mst_addr), .mst_wdata_o(mst_wdata),
    .mst_waitreq_i(waitreq), .irq_o(irq)
  );

  frame_cfg_sequencer #(.ONE_SHOT(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n),
    .s_valid_i(s_valid), .s_ready_o(s_ready1), .s_data_i(s_data), .s_sop_i(s_sop), .s_eop_i(s_eop),
    .m_valid_o(m_valid1), .m_ready_i(m_ready), .m_data_o(m_data1), .m_sop_o(m_sop1), .m_eop_o(m_eop1),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .ctl_we_i(ctl_we), .ctl_addr_i(ctl_addr), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata1),
    .mst_write_o(mst_write1), .mst_addr_o(mst_addr1), .mst_wdata_o(mst_wdata1),
    .mst_waitreq_i(1'b0), .irq_o(irq1)
  );

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // ---- logs filled at negedge
  int             wr_n = 0, bt_n = 0, wait_n = 0, stall_n = 0;
  logic [AW-1:0]  wr_a [64];
  logic [DW-1:0]  wr_d [64];
  int             wr_c [64];
  logic [SDW-1:0] bt_d [64];
  int             bt_c [64];

  always @(negedge clk) if (rst_n) begin
    if (mst_write && !waitreq && wr_n < 64) begin
      wr_a[wr_n] = mst_addr; wr_d[wr_n] = mst_wdata; wr_c[wr_n] = cyc; wr_n++;
    end
    if (mst_write && waitreq) wait_n++;
    if (m_valid && m_ready && bt_n < 64) begin
      bt_d[bt_n] = m_data; bt_c[bt_n] = cyc; bt_n++;
    end
    if (s_valid && !s_ready) stall_n++;
  end

  // wait-request generator: ws_cfg cycles of stretch per write
  int ws_cfg = 0, ws_cnt = 0;
  always @(posedge clk) begin
    #1;
    if (mst_write && ws_cnt < ws_cfg) begin waitreq = 1; ws_cnt++; end
    else begin waitreq = 0; ws_cnt = 0; end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_log();
    wr_n = 0; bt_n = 0; wait_n = 0; stall_n = 0;
  endtask

  task automatic cfg_wr(input int a, input logic [DW-1:0] d);
    cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = d;
    @(posedge clk); #1; cfg_we = 0;
  endtask

  task automatic ctl_wr(input logic a, input logic [DW-1:0] d);
    ctl_we = 1; ctl_addr = a; ctl_wdata = d;
    @(posedge clk); #1; ctl_we = 0;
  endtask

  task automatic ctl_rd(input logic a, output logic [DW-1:0] v0, output logic [DW-1:0] v1);
    ctl_addr = a;
    @(negedge clk); v0 = ctl_rdata; v1 = ctl_rdata1;
    @(posedge clk); #1;
  endtask

  function automatic logic [AW-1:0] exp_a(input int k);
    return 32'h4000_0000 + AW'(k * 16);
  endfunction
  function automatic logic [DW-1:0] exp_d(input int k, input int seed);
    return {16'(seed), 16'(k * 3 + 1)};
  endfunction

  task automatic prog(input int cnt, input int seed);
    cfg_wr(0, DW'(cnt));
    for (int k = 0; k < 8; k++) begin
      cfg_wr(2*k+1, exp_a(k));
      cfg_wr(2*k+2, exp_d(k, seed));
    end
  endtask

  task automatic send_beat(input logic [SDW-1:0] d, input logic sop, input logic eop);
    bit acc;
    s_valid = 1; s_data = d; s_sop = sop; s_eop = eop;
    forever begin
      acc = 0;
      @(negedge clk); if (s_ready) acc = 1;
      @(posedge clk); #1;
      if (acc) break;
    end
  endtask

  task automatic idle(input int n);
    s_valid = 0; s_sop = 0; s_eop = 0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send_video();
    send_beat(24'h123450, 1, 0);
    send_beat(24'h777777, 0, 0);
    send_beat(24'h888888, 0, 1);
    idle(3);
  endtask

  task automatic send_ctrl(input logic [15:0] w, input logic [15:0] h);
    send_beat(24'hA5A50F, 1, 0);
    send_beat({8'h11, w}, 0, 0);
    send_beat({8'h22, h}, 0, 0);
    send_beat(24'h333333, 0, 1);
    idle(3);
  endtask

  task automatic check_writes(input string tag, input int n, input int seed);
    chk({tag, " write count"}, 64'(wr_n), 64'(n));
    for (int k = 0; k < n && k < wr_n; k++) begin
      chk({tag, " addr order"}, 64'(wr_a[k]), 64'(exp_a(k)));
      chk({tag, " data order"}, 64'(wr_d[k]), 64'(exp_d(k, seed)));
    end
  endtask

  // ---- scenarios
  task automatic t_reset();
    logic [DW-1:0] v0, v1;
    @(negedge clk);
    chk("R1 reset m_valid", 64'(m_valid), 0);
    chk("R1 reset s_ready", 64'(s_ready), 1);
    chk("R4 reset mst_write", 64'(mst_write), 0);
    chk("R9 reset irq", 64'(irq), 0);
    @(posedge clk); #1;
    ctl_rd(0, v0, v1); chk("R7 reset enables", 64'(v0), 0);
    ctl_rd(1, v0, v1); chk("R9 reset pending", 64'(v0), 0);
  endtask

  task automatic t_passthrough_disabled();
    prog(2, 1);
    clr_log();
    send_video();
    send_ctrl(16'd640, 16'd480);
    chk("R1 beats forwarded", 64'(bt_n), 7);
    chk("R1 beat0 data", 64'(bt_d[0]), 64'h123450);
    chk("R1 beat2 data", 64'(bt_d[2]), 64'h888888);
    chk("R1 ctrl width beat", 64'(bt_d[4]), 64'h110280);
    chk("R7 no writes while disabled", 64'(wr_n), 0);
    chk("R7 no stall while disabled", 64'(stall_n), 0);
  endtask

  task automatic t_dims_tracked();
    ctl_wr(0, 1);
    clr_log();
    send_ctrl(16'd640, 16'd480);
    chk("R3 same dims no trigger (tracked while disabled, R7)", 64'(wr_n), 0);
    chk("R3 same dims no stall", 64'(stall_n), 0);
  endtask

  task automatic t_video_trigger();
    prog(3, 7);
    clr_log();
    send_video();
    check_writes("R4 video trigger", 3, 7);
    chk("R2 video sop stalls", 64'(stall_n > 0), 1);
    chk("R5 all beats forwarded once", 64'(bt_n), 3);
    chk("R5 held beat unchanged", 64'(bt_d[0]), 64'h123450);
    chk("R5 beat after last write", 64'(bt_c[0] > wr_c[2]), 1);
  endtask

  task automatic t_waitreq();
    prog(2, 9);
    ws_cfg = 2;
    clr_log();
    send_video();
    ws_cfg = 0;
    check_writes("R4 stretched", 2, 9);
    chk("R4 wait cycles observed", 64'(wait_n), 4);
    chk("R5 beat after stretched writes", 64'(bt_c[0] > wr_c[1]), 1);
  endtask

  task automatic t_ctrl_change();
    prog(3, 11);
    clr_log();
    send_ctrl(16'd800, 16'd600);
    check_writes("R3 both fields changed fires once", 3, 11);
    chk("R3 ctrl beats forwarded", 64'(bt_n), 4);
    clr_log();
    send_ctrl(16'd800, 16'd720);
    chk("R3 height only change", 64'(wr_n), 3);
    clr_log();
    send_ctrl(16'd800, 16'd720);
    chk("R3 unchanged dims", 64'(wr_n), 0);
  endtask

  task automatic t_other_type();
    clr_log();
    send_beat(24'h000003, 1, 0);
    send_beat(24'h000444, 0, 0);
    send_beat(24'h000555, 0, 1);
    idle(3);
    chk("R2 other type no trigger", 64'(wr_n), 0);
    chk("R2 other type forwarded", 64'(bt_n), 3);
  endtask

  task automatic t_count();
    logic [DW-1:0] v0, v1;
    ctl_wr(1, 1);
    prog(0, 3);
    clr_log();
    send_video();
    chk("R6 count 0 no writes", 64'(wr_n), 0);
    chk("R6 count 0 no stall", 64'(stall_n), 0);
    ctl_rd(1, v0, v1); chk("R6 count 0 no pending", 64'(v0[0]), 0);
    prog(12, 5);
    clr_log();
    send_video();
    check_writes("R6 count clamped to 8", 8, 5);
  endtask

  task automatic t_irq();
    logic [DW-1:0] v0, v1;
    ctl_rd(1, v0, v1); chk("R9 pending after sequence", 64'(v0[0]), 1);
    @(negedge clk); chk("R9 irq masked", 64'(irq), 0);
    @(posedge clk); #1;
    ctl_wr(0, 3);
    @(negedge clk); chk("R9 irq enabled", 64'(irq), 1);
    @(posedge clk); #1;
    ctl_wr(1, 0);
    ctl_rd(1, v0, v1); chk("R9 write 0 keeps pending", 64'(v0[0]), 1);
    ctl_wr(1, 1);
    ctl_rd(1, v0, v1); chk("R9 write 1 clears", 64'(v0[0]), 0);
    @(negedge clk); chk("R9 irq low after clear", 64'(irq), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_one_shot();
    logic [DW-1:0] v0, v1;
    ctl_wr(0, 1);
    prog(1, 2);
    clr_log();
    send_video();
    chk("R8 sequence ran", 64'(wr_n), 1);
    ctl_rd(0, v0, v1);
    chk("R8 repeat mode keeps enable", 64'(v0[0]), 1);
    chk("R8 one-shot clears enable", 64'(v1[0]), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_passthrough_disabled();
    t_dims_tracked();
    t_video_trigger();
    t_waitreq();
    t_ctrl_change();
    t_other_type();
    t_count();
    t_irq();
    t_one_shot();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule